// File: doc/BRIEF.md
# Load/Store Page Permission Checker

This block decides whether one memory access may go ahead, based on the page table entry that an earlier translation lookup returned. Each request comes with a valid flag, a load/store direction, a virtual-mode flag, a privileged-mode flag, the caller's own non-cacheable flag and a translation-hit flag. The block reads the referenced, changed, cache-inhibit, privileged-only, read and write bits of the entry. It then reports, one cycle later, whether the access may go ahead.

The registered result has the following parts:
- a go/error pair;
- the effective non-cacheable flag;
- exactly one fault class on an error: translation miss, permission, or reference/change;
- a 64-bit fault status word that uses big-endian bit numbering, so architected bit n sits at vector index 63-n.

In real mode the entry is not used, and a fixed attribute set takes its place.

Top module: `lsperm_check`

## Requirements
- R1: A synchronous active-high reset clears every output to zero.
- R2: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high. When it is low, `rsp_go`, `rsp_err`, `rsp_nc`, all three fault flags and `rsp_fsr` are zero.
- R3: For a valid request, `rsp_go` is high only when translation hit, the permission check passed and the reference/change check passed. `rsp_err` is the inverse of `rsp_go`.
- R4: In virtual mode, entry bit 8 (referenced) must be 1 for any access. If it is clear, and translation and permission passed, the result is a reference/change fault.
- R5: In virtual mode, a store also needs entry bit 7 (changed). A load ignores bit 7.
- R6: In virtual mode, when entry bit 3 (privileged-only) is set, only a request with `req_priv` high passes the permission check.
- R7: In virtual mode, a store needs entry bit 1 (write). A load needs entry bit 2 (read) or bit 1.
- R8: `rsp_nc` is `req_nc` ORed with entry bit 5 (cache-inhibit) in virtual mode.
- R9: In real mode (`req_virt` low) the entry is ignored. The attributes are taken as:
  - referenced, changed, readable and writable;
  - privileged-only;
  - cacheable.

  So a privileged real-mode request that hits always goes ahead with `rsp_nc` equal to `req_nc`, and a non-privileged one gets a permission fault.
- R10: At most one fault flag is high. The priority is translation miss (`xlat_hit` low), then permission, then reference/change.
- R11: `rsp_fsr` bits are set only on an error:
  - index 30 for a translation miss;
  - index 27 (architected 36) for a permission fault;
  - index 25 (architected 38) for a faulting store;
  - index 18 (architected 45) for a reference/change fault.

  All other bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_is_load | input | 1 | 1 = load, 0 = store |
| req_virt | input | 1 | 1 = virtual mode, entry is used |
| req_priv | input | 1 | 1 = privileged request |
| req_nc | input | 1 | Caller's non-cacheable flag |
| xlat_hit | input | 1 | Translation lookup found an entry |
| pte | input | PTE_W | Page table entry from the lookup |
| rsp_valid | output | 1 | Result present |
| rsp_go | output | 1 | Access may proceed |
| rsp_err | output | 1 | Access faulted |
| rsp_nc | output | 1 | Effective non-cacheable flag |
| rsp_miss | output | 1 | Translation miss fault |
| rsp_perm | output | 1 | Permission fault |
| rsp_rc | output | 1 | Reference/change fault |
| rsp_fsr | output | 64 | Fault status word, big-endian numbering |

## Verification
The assertions check, on every cycle, the properties that can be stated at the ports:
- the one-cycle response timing, and quiet outputs when there is no response;
- the exclusive go/error pair and the one-hot-or-none fault flags;
- the store flag in the status word;
- the rule that a privileged real-mode hit always goes ahead.

Only the bench's scenarios show how individual entry bits map to a decision, because each needs a chosen entry and request. These are:
- a missing changed bit that blocks a store but not a load;
- the privileged-only bit;
- read-only pages;
- cache-inhibit merging;
- each fault's exact status-word position.

// File: rtl/lsperm_pkg.sv
package lsperm_pkg;
    localparam int FSR_W = 64;

    // entry bit positions that the decision depends on
    localparam int PTE_REF  = 8;
    localparam int PTE_CHG  = 7;
    localparam int PTE_CI   = 5;
    localparam int PTE_SUPV = 3;
    localparam int PTE_RD   = 2;
    localparam int PTE_WR   = 1;

    // architected status bits, big-endian numbering
    localparam int ARCH_PERM  = 36;
    localparam int ARCH_STORE = 38;
    localparam int ARCH_RC    = 45;

    localparam int IDX_MISS  = 30;
    localparam int IDX_PERM  = FSR_W - 1 - ARCH_PERM;
    localparam int IDX_STORE = FSR_W - 1 - ARCH_STORE;
    localparam int IDX_RC    = FSR_W - 1 - ARCH_RC;

    typedef struct packed {
        logic refd;
        logic chgd;
        logic inhib;
        logic supv;
        logic rd_ok;
        logic wr_ok;
    } page_attr_t;

    typedef struct packed {
        logic             valid;
        logic             go;
        logic             err;
        logic             nc;
        logic             f_miss;
        logic             f_perm;
        logic             f_rc;
        logic [FSR_W-1:0] fsr;
    } chk_result_t;
endpackage

// File: rtl/lsperm_attr_sel.sv
module lsperm_attr_sel
    import lsperm_pkg::*;
#(
    parameter int PTE_W = 64
) (
    input  logic             virt,
    input  logic [PTE_W-1:0] pte,
    output page_attr_t       attr
);
    // real mode: full access, privileged-only, cacheable (R9)
    localparam page_attr_t REAL_ATTR = '{refd: 1'b1, chgd: 1'b1, inhib: 1'b0,
                                         supv: 1'b1, rd_ok: 1'b1, wr_ok: 1'b1};

    always_comb begin
        if (virt) begin
            attr.refd  = pte[PTE_REF];
            attr.chgd  = pte[PTE_CHG];
            attr.inhib = pte[PTE_CI];
            attr.supv  = pte[PTE_SUPV];
            attr.rd_ok = pte[PTE_RD];
            attr.wr_ok = pte[PTE_WR];
        end else begin
            attr = REAL_ATTR;
        end
    end
endmodule

// File: rtl/lsperm_rule.sv
module lsperm_rule
    import lsperm_pkg::*;
(
    input  page_attr_t attr,
    input  logic       is_load,
    input  logic       priv,
    output logic       perm_ok,
    output logic       rc_ok
);
    logic mode_ok;
    logic dir_ok;

    always_comb begin
        mode_ok = priv | ~attr.supv;                         // R6
        dir_ok  = attr.wr_ok | (is_load & attr.rd_ok);        // R7
        perm_ok = mode_ok & dir_ok;
        rc_ok   = attr.refd & (is_load | attr.chgd);          // R4 R5
    end
endmodule

// File: rtl/lsperm_check.sv
module lsperm_check
    import lsperm_pkg::*;
#(
    parameter int PTE_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_is_load,
    input  logic             req_virt,
    input  logic             req_priv,
    input  logic             req_nc,
    input  logic             xlat_hit,
    input  logic [PTE_W-1:0] pte,
    output logic             rsp_valid,
    output logic             rsp_go,
    output logic             rsp_err,
    output logic             rsp_nc,
    output logic             rsp_miss,
    output logic             rsp_perm,
    output logic             rsp_rc,
    output logic [FSR_W-1:0] rsp_fsr
);
    page_attr_t  attr;
    logic        perm_ok;
    logic        rc_ok;
    chk_result_t res_d, res_q;

    lsperm_attr_sel #(.PTE_W(PTE_W)) u_attr (
        .virt (req_virt),
        .pte  (pte),
        .attr (attr)
    );

    lsperm_rule u_rule (
        .attr    (attr),
        .is_load (req_is_load),
        .priv    (req_priv),
        .perm_ok (perm_ok),
        .rc_ok   (rc_ok)
    );

    always_comb begin
        res_d = '0;
        if (req_valid) begin
            res_d.valid  = 1'b1;
            res_d.go     = xlat_hit & perm_ok & rc_ok;        // R3
            res_d.err    = ~res_d.go;
            res_d.nc     = req_nc | attr.inhib;               // R8
            res_d.f_miss = ~xlat_hit;                         // R10 priority
            res_d.f_perm = xlat_hit & ~perm_ok;
            res_d.f_rc   = xlat_hit & perm_ok & ~rc_ok;
            res_d.fsr[IDX_MISS]  = res_d.f_miss;              // R11
            res_d.fsr[IDX_PERM]  = res_d.f_perm;
            res_d.fsr[IDX_RC]    = res_d.f_rc;
            res_d.fsr[IDX_STORE] = res_d.err & ~req_is_load;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) res_q <= '0;                                 // R1
        else     res_q <= res_d;
    end

    assign rsp_valid = res_q.valid;
    assign rsp_go    = res_q.go;
    assign rsp_err   = res_q.err;
    assign rsp_nc    = res_q.nc;
    assign rsp_miss  = res_q.f_miss;
    assign rsp_perm  = res_q.f_perm;
    assign rsp_rc    = res_q.f_rc;
    assign rsp_fsr   = res_q.fsr;

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);                                           // R2
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);                                         // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> (!rsp_go && !rsp_err && !rsp_nc && rsp_fsr == '0));  // R2
    AST_GO_XOR_ERR: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_go ^ rsp_err));                                  // R3
    AST_ONE_FAULT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rsp_miss, rsp_perm, rsp_rc}) && (rsp_err == (rsp_miss | rsp_perm | rsp_rc))); // R10
    AST_STORE_FLAG: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> (rsp_fsr[IDX_STORE] == $past(!req_is_load)));           // R11
    AST_REAL_PRIV_GO: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_virt && req_priv && xlat_hit) |=> (rsp_go && rsp_nc == $past(req_nc))); // R9
endmodule

// File: tb/lsperm_check_tb.sv
module lsperm_check_tb;
    localparam int CLK_PERIOD = 10;
    localparam int PTE_W = 64;
    localparam int OW = 71;

    logic clk = 1'b0;
    logic rst, req_valid, req_is_load, req_virt, req_priv, req_nc, xlat_hit;
    logic [PTE_W-1:0] pte;
    logic rsp_valid, rsp_go, rsp_err, rsp_nc, rsp_miss, rsp_perm, rsp_rc;
    logic [63:0] rsp_fsr;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lsperm_check #(.PTE_W(PTE_W)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_is_load(req_is_load),
        .req_virt(req_virt), .req_priv(req_priv), .req_nc(req_nc), .xlat_hit(xlat_hit),
        .pte(pte), .rsp_valid(rsp_valid), .rsp_go(rsp_go), .rsp_err(rsp_err),
        .rsp_nc(rsp_nc), .rsp_miss(rsp_miss), .rsp_perm(rsp_perm), .rsp_rc(rsp_rc),
        .rsp_fsr(rsp_fsr)
    );

    // expected {valid,go,err,nc,miss,perm,rc,fsr} from the requirements
    function automatic logic [OW-1:0] model(input logic v, ld, vm, pr, nc, hit,
                                             input logic [PTE_W-1:0] p);
        logic rf, ch, ci, sv, rd, wr, pok, rok, go, m, pf, rf_f;
        logic [63:0] f;
        if (!v) return '0;
        if (vm) begin
            rf = p[8]; ch = p[7]; ci = p[5]; sv = p[3]; rd = p[2]; wr = p[1];
        end else begin
            rf = 1; ch = 1; ci = 0; sv = 1; rd = 1; wr = 1;
        end
        pok  = (pr || !sv) && (wr || (ld && rd));
        rok  = rf && (ld || ch);
        go   = hit && pok && rok;
        m    = !hit;
        pf   = hit && !pok;
        rf_f = hit && pok && !rok;
        f = '0;
        f[30] = m; f[27] = pf; f[18] = rf_f; f[25] = !go && !ld;
        return {1'b1, go, !go, nc || ci, m, pf, rf_f, f};
    endfunction

    function automatic logic [OW-1:0] actual();
        return {rsp_valid, rsp_go, rsp_err, rsp_nc, rsp_miss, rsp_perm, rsp_rc, rsp_fsr};
    endfunction

    task automatic drive(input logic v, ld, vm, pr, nc, hit, input logic [PTE_W-1:0] p);
        req_valid = v; req_is_load = ld; req_virt = vm; req_priv = pr;
        req_nc = nc; xlat_hit = hit; pte = p;
    endtask

    // inputs set at negedge, result registered at posedge, sampled at next negedge
    task automatic apply(input string tag, input logic v, ld, vm, pr, nc, hit,
                         input logic [PTE_W-1:0] p);
        logic [OW-1:0] exp_v;
        drive(v, ld, vm, pr, nc, hit, p);
        exp_v = model(v, ld, vm, pr, nc, hit, p);
        @(negedge clk);
        checks++;
        if (actual() !== exp_v) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, actual(), exp_v);
        end
    endtask

    // entry helper: ref, chg, ci, supv, rd, wr
    function automatic logic [PTE_W-1:0] mk(input logic rf, ch, ci, sv, rd, wr);
        logic [PTE_W-1:0] p = '0;
        p[8] = rf; p[7] = ch; p[5] = ci; p[3] = sv; p[2] = rd; p[1] = wr;
        return p;
    endfunction

    initial begin
        #(CLK_PERIOD * 5000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        rst = 1'b1;
        drive(1, 1, 1, 1, 1, 1, mk(1, 1, 1, 0, 1, 1));
        @(negedge clk); @(negedge clk);
        checks++;
        if (actual() !== '0) begin
            errors++;
            $display("FAIL R1: actual=%h expected=0", actual());
        end
        rst = 1'b0;

        apply("R2 idle", 0, 1, 1, 1, 1, 1, mk(1, 1, 1, 0, 1, 1));
        apply("R3 full pass", 1, 1, 1, 0, 0, 1, mk(1, 1, 0, 0, 1, 1));
        apply("R4 ref clear load", 1, 1, 1, 1, 0, 1, mk(0, 1, 0, 0, 1, 1));
        apply("R5 chg clear store", 1, 0, 1, 1, 0, 1, mk(1, 0, 0, 0, 1, 1));
        apply("R5 chg clear load ok", 1, 1, 1, 1, 0, 1, mk(1, 0, 0, 0, 1, 0));
        apply("R6 supv page user", 1, 1, 1, 0, 0, 1, mk(1, 1, 0, 1, 1, 1));
        apply("R6 supv page priv", 1, 1, 1, 1, 0, 1, mk(1, 1, 0, 1, 1, 1));
        apply("R7 read-only store", 1, 0, 1, 1, 0, 1, mk(1, 1, 0, 0, 1, 0));
        apply("R7 write-only load", 1, 1, 1, 1, 0, 1, mk(1, 1, 0, 0, 0, 1));
        apply("R7 no access load", 1, 1, 1, 1, 0, 1, mk(1, 1, 0, 0, 0, 0));
        apply("R8 inhibit bit", 1, 1, 1, 1, 0, 1, mk(1, 1, 1, 0, 1, 1));
        apply("R9 real priv ignores pte", 1, 0, 0, 1, 0, 1, '0);
        apply("R9 real user", 1, 1, 0, 0, 1, 1, '1);
        apply("R10 miss beats perm", 1, 0, 1, 0, 0, 0, mk(0, 0, 0, 1, 0, 0));
        apply("R10 perm beats rc", 1, 0, 1, 1, 0, 1, mk(0, 0, 0, 0, 1, 0));
        apply("R11 store miss status", 1, 0, 1, 1, 1, 0, mk(1, 1, 0, 0, 1, 1));
        apply("R2 back to idle", 0, 0, 1, 1, 0, 1, '0);

        for (int i = 0; i < 400; i++) begin
            logic [PTE_W-1:0] p;
            logic [6:0] r;
            p = {$urandom, $urandom};
            r = 7'($urandom);
            apply("R3 random", r[0] | r[6], r[1], r[2], r[3], r[4], r[5] | r[6], p);
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule